// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block collects a parameterized set of interrupt sources and decides, for a processor core, whether a high-level or a low-level interrupt should be entered. Each source carries a pending flag, an enable bit and a level bit. A control register holds the two gating bits and the level-mode bit. Which of the two gating bits applies to which sources depends on whether level mode is on. A single register port, with one address for both reads and writes, reaches the control, flag, enable and level registers.

The core reports instruction boundaries with a strobe. When a permitted request is pending at a boundary, the controller signals entry and presents the vector address. In the same cycle it clears the gating bit that belongs to the level being entered, marks that level as in service, and saves three core register values in a one-deep shadow. A return strobe leaves the innermost level in service and turns its gating bit back on. When the return's fast bit is set, the controller also presents the shadow contents for the core to restore.

Top module: `irq_two_level`

## Requirements
- R1: After reset, all flags, enables, level bits, the control register (bit 0 global/high gate, bit 1 peripheral/low gate, bit 2 level mode, bit 3 low in service, bit 4 high in service) and both request outputs are 0.
- R2: A one-cycle pulse on a source's event input sets its flag. The flag is cleared by writing 0 to its bit of the flag register (address 1) or by a pulse on its clear input; writing 1 sets it. A set in the same cycle as a clear or a write of 0 leaves the flag at 1.
- R3: A source contributes to a request only when its flag bit and its enable bit (address 2) are both 1.
- R4: With level mode off, every source is high level with vector 0x0008 and req_lo_o stays 0. Control bit 0 gates all sources, and control bit 1 additionally gates the sources marked in PERIPH_MASK.
- R5: With level mode on, a source whose level bit (address 3) is 1 requests the high level (vector 0x0008) gated by control bit 0. A source whose level bit is 0 requests the low level (vector 0x0018) gated by control bit 1. When both levels request, vec_o shows 0x0008.
- R6: Entry happens only in a cycle with boundary_i high and a request pending. take_o and vec_o are valid in that same cycle, and a request held across cycles without a boundary causes no entry and no state change.
- R7: On a high entry, control bit 0 is cleared and bit 4 is set. On a low entry, control bit 1 is cleared and bit 3 is set. On the same edge, hardware updates take precedence over a register write.
- R8: A high request may enter while the low level is in service. While the high level is in service, neither level can request, even with its gate set again by software. A low request cannot enter while the low level is in service.
- R9: Every entry copies w_i, status_i and bsr_i into the shadow. restore_o is high only during a return with fast_i set, and the shadow values are presented on w_o, status_o and bsr_o.
- R10: A high entry that follows a low entry overwrites the shadow, so the next fast return presents the high entry's values.
- R11: A return clears the in-service bit of the innermost level (high before low) and sets that level's gate bit again (bit 0 for high or without level mode, bit 1 for low). A pending request may then enter again.
- R12: Writes to control bits 3 and 4 are ignored. Reads of addresses 0 to 3 return the control, flag, enable and level registers in the next cycle after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address for read and write |
| wdata_i | input | N_SRC | Write data |
| rdata_o | output | N_SRC | Read data of the addressed register |
| evt_i | input | N_SRC | Per-source event pulses (set flag) |
| clr_i | input | N_SRC | Per-source flag clear pulses |
| boundary_i | input | 1 | Instruction boundary strobe from core |
| retfie_i | input | 1 | Return-from-interrupt strobe |
| fast_i | input | 1 | Fast return qualifier (restore shadow) |
| w_i | input | CORE_W | Core working register value |
| status_i | input | CORE_W | Core status register value |
| bsr_i | input | CORE_W | Core bank select value |
| req_hi_o | output | 1 | High level request pending |
| req_lo_o | output | 1 | Low level request pending |
| take_o | output | 1 | Interrupt entered this cycle |
| vec_o | output | VEC_W | Vector address of the level being requested |
| restore_o | output | 1 | Shadow restore strobe on fast return |
| w_o | output | CORE_W | Shadow working register |
| status_o | output | CORE_W | Shadow status register |
| bsr_o | output | CORE_W | Shadow bank select |

## Verification
The request outputs, take_o, vec_o and restore_o are combinational from registered state and the current strobes, so they are due in the cycle the stimulus is applied. The bench samples them one time unit after driving at the falling edge, before the next rising edge. Flag, enable, control and in-service changes and the shadow capture all land on the next rising edge. The bench therefore reads those through the register port at the falling edge that follows. No check depends on a result that is two or more edges away.

// File: rtl/irq_tl_pkg.sv
package irq_tl_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_FLAG = 2'd1,
    SEL_EN   = 2'd2,
    SEL_LVL  = 2'd3
  } reg_sel_e;

  localparam int CB_GATE_HI = 0;
  localparam int CB_GATE_LO = 1;
  localparam int CB_LVL_MD  = 2;
  localparam int CB_INS_LO  = 3;
  localparam int CB_INS_HI  = 4;
  localparam int CTRL_W     = 5;
endpackage

// File: rtl/irq_flags.sv
module irq_flags #(
  parameter int N_SRC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] evt_i,
  input  logic [N_SRC-1:0] clr_i,
  input  logic             wr_i,
  input  logic [N_SRC-1:0] wdata_i,
  output logic [N_SRC-1:0] flag_o
);
  for (genvar k = 0; k < N_SRC; k++) begin : g_flag
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       q <= 1'b0;
      else if (evt_i[k])                 q <= 1'b1;  // set wins
      else if (clr_i[k])                 q <= 1'b0;
      else if (wr_i)                     q <= wdata_i[k];
    end
    assign flag_o[k] = q;

    assert_evt_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[k] |=> q);
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int               N_SRC       = 8,
  parameter logic [N_SRC-1:0] PERIPH_MASK = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] flag_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic [N_SRC-1:0] lvl_i,
  input  logic             gate_hi_i,
  input  logic             gate_lo_i,
  input  logic             lvl_md_i,
  input  logic             ins_hi_i,
  input  logic             ins_lo_i,
  output logic             req_hi_o,
  output logic             req_lo_o
);
  logic [N_SRC-1:0] live;
  logic [N_SRC-1:0] flat_ok;
  logic             hi_cand, lo_cand, flat_cand;

  always_comb begin
    live      = flag_i & en_i;
    flat_ok   = live & (~PERIPH_MASK | {N_SRC{gate_lo_i}});
    flat_cand = |flat_ok;
    hi_cand   = |(live & lvl_i);
    lo_cand   = |(live & ~lvl_i);
    if (!lvl_md_i) begin
      req_hi_o = gate_hi_i & flat_cand & ~ins_hi_i;
      req_lo_o = 1'b0;
    end else begin
      req_hi_o = gate_hi_i & hi_cand & ~ins_hi_i;
      req_lo_o = gate_lo_i & lo_cand & ~ins_hi_i & ~ins_lo_i;
    end
  end

  assert_hi_blocks_all_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_hi_i |-> (!req_hi_o && !req_lo_o));
  assert_no_live_no_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flag_i & en_i) == '0) |-> (!req_hi_o && !req_lo_o));
  assert_flat_no_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lvl_md_i |-> !req_lo_o);
endmodule

// File: rtl/irq_shadow.sv
module irq_shadow #(
  parameter int CORE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              save_i,
  input  logic [CORE_W-1:0] w_i,
  input  logic [CORE_W-1:0] status_i,
  input  logic [CORE_W-1:0] bsr_i,
  output logic [CORE_W-1:0] w_o,
  output logic [CORE_W-1:0] status_o,
  output logic [CORE_W-1:0] bsr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_o      <= '0;
      status_o <= '0;
      bsr_o    <= '0;
    end else if (save_i) begin
      w_o      <= w_i;
      status_o <= status_i;
      bsr_o    <= bsr_i;
    end
  end

  assert_save_copies_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_i |=> (w_o == $past(w_i) && status_o == $past(status_i) && bsr_o == $past(bsr_i)));
endmodule

// File: rtl/irq_two_level.sv
module irq_two_level
  import irq_tl_pkg::*;
#(
  parameter int               N_SRC       = 8,
  parameter int               CORE_W      = 8,
  parameter int               VEC_W       = 16,
  parameter logic [N_SRC-1:0] PERIPH_MASK = 8'hF0,
  parameter logic [VEC_W-1:0] HI_VEC      = 16'h0008,
  parameter logic [VEC_W-1:0] LO_VEC      = 16'h0018
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [N_SRC-1:0]  wdata_i,
  output logic [N_SRC-1:0]  rdata_o,
  input  logic [N_SRC-1:0]  evt_i,
  input  logic [N_SRC-1:0]  clr_i,
  input  logic              boundary_i,
  input  logic              retfie_i,
  input  logic              fast_i,
  input  logic [CORE_W-1:0] w_i,
  input  logic [CORE_W-1:0] status_i,
  input  logic [CORE_W-1:0] bsr_i,
  output logic              req_hi_o,
  output logic              req_lo_o,
  output logic              take_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              restore_o,
  output logic [CORE_W-1:0] w_o,
  output logic [CORE_W-1:0] status_o,
  output logic [CORE_W-1:0] bsr_o
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(addr_i);

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [N_SRC-1:0]  en_q, lvl_q, flag;
  logic              take_hi, take_lo;

  irq_flags #(.N_SRC(N_SRC)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt_i),
    .clr_i   (clr_i),
    .wr_i    (wr_en_i && sel == SEL_FLAG),
    .wdata_i (wdata_i),
    .flag_o  (flag)
  );

  irq_arbiter #(.N_SRC(N_SRC), .PERIPH_MASK(PERIPH_MASK)) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flag_i    (flag),
    .en_i      (en_q),
    .lvl_i     (lvl_q),
    .gate_hi_i (ctrl_q[CB_GATE_HI]),
    .gate_lo_i (ctrl_q[CB_GATE_LO]),
    .lvl_md_i  (ctrl_q[CB_LVL_MD]),
    .ins_hi_i  (ctrl_q[CB_INS_HI]),
    .ins_lo_i  (ctrl_q[CB_INS_LO]),
    .req_hi_o  (req_hi_o),
    .req_lo_o  (req_lo_o)
  );

  irq_shadow #(.CORE_W(CORE_W)) u_shadow (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .save_i   (take_o),
    .w_i      (w_i),
    .status_i (status_i),
    .bsr_i    (bsr_i),
    .w_o      (w_o),
    .status_o (status_o),
    .bsr_o    (bsr_o)
  );

  assign take_hi   = boundary_i & req_hi_o;
  assign take_lo   = boundary_i & req_lo_o & ~req_hi_o;
  assign take_o    = take_hi | take_lo;
  assign vec_o     = req_hi_o ? HI_VEC : LO_VEC;
  assign restore_o = retfie_i & fast_i;

  // software write, then return, then entry: later steps override
  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en_i && sel == SEL_CTRL) begin
      ctrl_d[CB_GATE_HI] = wdata_i[CB_GATE_HI];
      ctrl_d[CB_GATE_LO] = wdata_i[CB_GATE_LO];
      ctrl_d[CB_LVL_MD]  = wdata_i[CB_LVL_MD];
    end
    if (retfie_i) begin
      if (ctrl_q[CB_INS_HI]) begin
        ctrl_d[CB_INS_HI]  = 1'b0;
        ctrl_d[CB_GATE_HI] = 1'b1;
      end else if (ctrl_q[CB_INS_LO]) begin
        ctrl_d[CB_INS_LO] = 1'b0;
        if (ctrl_q[CB_LVL_MD]) ctrl_d[CB_GATE_LO] = 1'b1;
        else                   ctrl_d[CB_GATE_HI] = 1'b1;
      end else begin
        ctrl_d[CB_GATE_HI] = 1'b1;
      end
    end
    if (take_hi) begin
      ctrl_d[CB_INS_HI]  = 1'b1;
      ctrl_d[CB_GATE_HI] = 1'b0;
    end else if (take_lo) begin
      ctrl_d[CB_INS_LO]  = 1'b1;
      ctrl_d[CB_GATE_LO] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      en_q   <= '0;
      lvl_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      if (wr_en_i && sel == SEL_EN)  en_q  <= wdata_i;
      if (wr_en_i && sel == SEL_LVL) lvl_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      SEL_CTRL: rdata_o[CTRL_W-1:0] = ctrl_q;
      SEL_FLAG: rdata_o = flag;
      SEL_EN:   rdata_o = en_q;
      SEL_LVL:  rdata_o = lvl_q;
    endcase
  end

  assert_hi_entry_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_hi |=> (!ctrl_q[CB_GATE_HI] && ctrl_q[CB_INS_HI]));
  assert_lo_entry_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_lo |=> (!ctrl_q[CB_GATE_LO] && ctrl_q[CB_INS_LO]));
  assert_take_at_boundary_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> boundary_i);
  assert_hi_vector_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_hi |-> vec_o == HI_VEC);
  assert_lo_vector_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_lo |-> vec_o == LO_VEC);
  assert_no_entry_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!boundary_i && !retfie_i && !wr_en_i) |=> $stable(ctrl_q));
endmodule

// File: tb/tb_irq_two_level.sv
module tb_irq_two_level;
  localparam int N = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, boundary = 1'b0, retfie = 1'b0, fast = 1'b0;
  logic [1:0] addr = '0;
  logic [N-1:0] wdata = '0, evt = '0, clr = '0, rdata;
  logic [7:0] w = '0, st = '0, bs = '0, w_s, st_s, bs_s;
  logic req_hi, req_lo, take, restore;
  logic [15:0] vec;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  irq_two_level dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .evt_i(evt), .clr_i(clr), .boundary_i(boundary),
    .retfie_i(retfie), .fast_i(fast), .w_i(w), .status_i(st), .bsr_i(bs),
    .req_hi_o(req_hi), .req_lo_o(req_lo), .take_o(take), .vec_o(vec),
    .restore_o(restore), .w_o(w_s), .status_o(st_s), .bsr_o(bs_s)
  );

  typedef struct packed {
    logic [2:0]  ctl;
    logic [7:0]  en;
    logic [7:0]  lvl;
    logic [7:0]  flg;
    logic        hi;
    logic        lo;
    logic [15:0] vec;
  } row_t;

  // PERIPH_MASK default 8'hF0
  localparam row_t TBL [10] = '{
    '{3'b000, 8'hFF, 8'h00, 8'h01, 1'b0, 1'b0, 16'h0018},  // R4 gate off
    '{3'b001, 8'h01, 8'h00, 8'h01, 1'b1, 1'b0, 16'h0008},  // R4 flat core src
    '{3'b001, 8'h10, 8'h00, 8'h10, 1'b0, 1'b0, 16'h0018},  // R4 periph gated
    '{3'b011, 8'h10, 8'h00, 8'h10, 1'b1, 1'b0, 16'h0008},  // R4 periph open
    '{3'b011, 8'h02, 8'h00, 8'h01, 1'b0, 1'b0, 16'h0018},  // R3 enable missing
    '{3'b111, 8'h03, 8'h01, 8'h02, 1'b0, 1'b1, 16'h0018},  // R5 low
    '{3'b101, 8'h03, 8'h00, 8'h03, 1'b0, 1'b0, 16'h0018},  // R5 low gate off
    '{3'b110, 8'h01, 8'h01, 8'h01, 1'b0, 1'b0, 16'h0018},  // R5 high gate off
    '{3'b111, 8'h03, 8'h01, 8'h03, 1'b1, 1'b1, 16'h0008},  // R5 both, high vector
    '{3'b011, 8'h00, 8'h00, 8'hFF, 1'b0, 1'b0, 16'h0018}   // R3 none enabled
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse_evt(input logic [7:0] m);
    @(negedge clk); evt = m;
    @(negedge clk); evt = '0;
  endtask

  // drive boundary for one cycle; check take/vec before the edge
  task automatic enter(input logic [7:0] wv, input logic [15:0] exp_vec, input string tag);
    @(negedge clk); boundary = 1'b1; w = wv; st = wv + 8'd1; bs = wv + 8'd2; #1;
    chk({tag, " take"}, take, 1);
    chk({tag, " vec"}, vec, exp_vec);
    @(negedge clk); boundary = 1'b0;
  endtask

  task automatic leave(input logic f, input logic [7:0] wv, input string tag);
    @(negedge clk); retfie = 1'b1; fast = f; #1;
    chk({tag, " restore"}, restore, f);
    if (f) begin
      chk({tag, " w"}, w_s, wv);
      chk({tag, " status"}, st_s, wv + 8'd1);
      chk({tag, " bsr"}, bs_s, wv + 8'd2);
    end
    @(negedge clk); retfie = 1'b0; fast = 1'b0;
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v); chk("R1 reg after reset", v, 0);
    end
    chk("R1 req_hi", req_hi, 0);
    chk("R1 req_lo", req_lo, 0);

    // table walk: R3 R4 R5
    for (int i = 0; i < 10; i++) begin
      wr(2'd2, TBL[i].en);
      wr(2'd3, TBL[i].lvl);
      wr(2'd1, TBL[i].flg);
      wr(2'd0, {5'd0, TBL[i].ctl});
      #1;
      chk($sformatf("R4/R5 row %0d req_hi", i), req_hi, TBL[i].hi);
      chk($sformatf("R4/R5 row %0d req_lo", i), req_lo, TBL[i].lo);
      if (TBL[i].hi || TBL[i].lo) chk($sformatf("R5 row %0d vec", i), vec, TBL[i].vec);
      wr(2'd0, 8'h00);
      wr(2'd1, 8'h00);
    end

    // R12 in-service bits not writable
    wr(2'd0, 8'h1F);
    rd(2'd0, v); chk("R12 ctrl write mask", v, 8'h07);
    wr(2'd0, 8'h00);
    wr(2'd2, 8'hA5);
    rd(2'd2, v); chk("R12 enable readback", v, 8'hA5);

    // R2 flag set/clear/collisions
    pulse_evt(8'h04);
    rd(2'd1, v); chk("R2 event sets", v, 8'h04);
    @(negedge clk); clr = 8'h04; @(negedge clk); clr = '0;
    rd(2'd1, v); chk("R2 clear input", v, 8'h00);
    @(negedge clk); evt = 8'h04; clr = 8'h04; @(negedge clk); evt = '0; clr = '0;
    rd(2'd1, v); chk("R2 set beats clear", v, 8'h04);
    @(negedge clk); evt = 8'h04; wr_en = 1'b1; addr = 2'd1; wdata = 8'h00;
    @(negedge clk); evt = '0; wr_en = 1'b0;
    rd(2'd1, v); chk("R2 set beats write", v, 8'h04);
    wr(2'd1, 8'h00);
    rd(2'd1, v); chk("R2 write clears", v, 8'h00);

    // flat mode entry: R6 R7 R9 R11
    wr(2'd2, 8'h01); wr(2'd3, 8'h00); wr(2'd0, 8'h01);
    pulse_evt(8'h01);
    repeat (3) @(negedge clk);
    #1; chk("R6 held request", req_hi, 1);
    rd(2'd0, v); chk("R6 no entry without boundary", v, 8'h01);
    enter(8'hA0, 16'h0008, "R6 flat");
    rd(2'd0, v); chk("R7 flat entry ctrl", v, 8'h10);
    #1; chk("R8 high blocks high", req_hi, 0);
    leave(1'b1, 8'hA0, "R9 flat fast");
    rd(2'd0, v); chk("R11 flat return ctrl", v, 8'h01);
    #1; chk("R11 re-request", req_hi, 1);
    enter(8'h30, 16'h0008, "R6 flat again");
    leave(1'b0, 8'h30, "R9 slow return");
    wr(2'd1, 8'h00); wr(2'd0, 8'h00);

    // level mode nesting: R8 R10 R11
    wr(2'd2, 8'h03); wr(2'd3, 8'h01); wr(2'd0, 8'h07);
    pulse_evt(8'h02);
    #1; chk("R5 low request", req_lo, 1);
    enter(8'h11, 16'h0018, "R5 low entry");
    rd(2'd0, v); chk("R7 low entry ctrl", v, 8'h0D);
    #1; chk("R8 low blocks low", req_lo, 0);
    pulse_evt(8'h01);
    #1; chk("R8 high preempts low", req_hi, 1);
    enter(8'h22, 16'h0008, "R8 nested high");
    rd(2'd0, v); chk("R7 nested ctrl", v, 8'h1C);
    wr(2'd0, 8'h07);
    #1; chk("R8 high in service blocks high", req_hi, 0);
    chk("R8 high in service blocks low", req_lo, 0);
    leave(1'b1, 8'h22, "R10 shadow overwritten");
    rd(2'd0, v); chk("R11 high exit ctrl", v, 8'h0F);
    #1; chk("R11 high re-request", req_hi, 1);
    wr(2'd1, 8'h00);
    leave(1'b0, 8'h00, "R11 low exit");
    rd(2'd0, v); chk("R11 low exit ctrl", v, 8'h07);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule